// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sequences one auxiliary-channel request into a series of single attempts. For every attempt it raises a launch strobe. The attempt engine, which is a separate block, then reports the result. That report carries status flags, a four-bit reply code and the count of reply bytes. The controller sorts each result into a failure category and updates that category's retry budget. It then ends the request with a success or fail strobe, or it schedules another attempt.

Each failure category has its own saturating counter and its own limit. Some results clear the counters of other categories. The number of attempts per request has a hard ceiling. Some categories need a pause before the next attempt. These pauses are counted in pulses of a one-microsecond tick input. A defer pause is given in milliseconds and counts 1000 ticks per unit.

The request direction and length are captured when the start is accepted. The defer delay is sampled at the moment each attempt is judged.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A request makes at most 7 attempts. A retryable result on the 7th attempt ends the request with a fail. `launch_o` is a single-cycle pulse, one per attempt.
- R2: Results are sorted in this priority order. First, `st_hpd_i` fails the request at once. Next, a timeout is any bit of `st_tmo_i`. Next, an invalid reply is any bit of `st_inv_i`, or `rep_bytes_i` equal to 0. Only when none of these apply is the reply code used.
- R3: A result that is neither a timeout, an invalid reply nor a disconnect clears the timeout and invalid-reply counters.
- R4: Reply code 0x0 (ACK) ends the request with success. The exception is a read whose returned payload (`rep_bytes_i` − 1) is smaller than the captured length. Writes succeed, and so do reads with equal or larger payloads.
- R5: A short read increments an ACK counter and fails when that counter reaches 7. Otherwise the next attempt waits 300 ticks.
- R6: Codes 0x2 (native defer), 0x4 (I2C NACK) and 0x8 (I2C relay defer) increment one shared defer counter. The request fails when that counter reaches 7.
- R7: After code 0x2 or 0x8, the retry waits `defer_ms_i`×1000 ticks when `defer_ms_i` is nonzero, and waits nothing when it is zero. After code 0x4 the retry never waits.
- R8: Code 0xC (I2C bus defer) clears the shared defer counter and increments its own counter. The request fails when that counter reaches 7. Otherwise it retries with no wait.
- R9: Code 0x1 (native NACK) and every code not listed here fail the request at once.
- R10: An invalid reply fails on its 2nd occurrence. Otherwise the next attempt waits 400 ticks.
- R11: A timeout fails on its 3rd occurrence. Otherwise it retries with no wait.
- R12: A retry without a wait launches in the cycle after the `att_done_i` cycle. A wait of W ticks, with `tick_us_i` held high, launches W+1 cycles later than that. A slower tick stretches the wait accordingly.
- R13: After reset all outputs are low. `busy_o` is high from the cycle after an accepted start until the cycle of the done strobe, in which it is low. While busy, `start_i` is ignored. While no attempt is outstanding, `att_done_i` is ignored.
- R14: `done_ok_o` and `done_fail_o` are one-cycle pulses, never both high at once. Either one appears in the cycle after the deciding `att_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a request (accepted only when idle) |
| is_read_i | input | 1 | Request is a read, captured at start |
| req_len_i | input | LEN_W | Requested payload length, captured at start |
| defer_ms_i | input | DLY_W | Defer wait in milliseconds |
| tick_us_i | input | 1 | One pulse per microsecond |
| att_done_i | input | 1 | Attempt result valid |
| st_hpd_i | input | 1 | Sink disconnected during attempt |
| st_tmo_i | input | 2 | Timeout status flags |
| st_inv_i | input | 4 | Invalid-reply status flags |
| reply_i | input | 4 | Reply code |
| rep_bytes_i | input | LEN_W+1 | Reply bytes received including the code byte |
| launch_o | output | 1 | Start one attempt |
| busy_o | output | 1 | Request in progress |
| done_ok_o | output | 1 | Request succeeded |
| done_fail_o | output | 1 | Request failed |

## Verification
A budget counter that is wrong shows up as a wrong number of launches before the final strobe. A cross-clear that is missing or misplaced shows the same way, with the request ending one or more attempts early or late. A wrong classification or wait choice changes the gap between an attempt's result and the next launch; that gap is exact to the cycle, so the error is visible at the very next launch. A stuck state machine shows as a missing strobe, or as `busy_o` held high, within one attempt's time.

// File: rtl/aux_retry_pkg.sv
`timescale 1ns/1ps
package aux_retry_pkg;

  typedef enum logic [3:0] {
    CL_HPD, CL_TMO, CL_INV, CL_ACK_OK, CL_ACK_SHORT,
    CL_NDEFER, CL_I2C_NACK, CL_RDEFER, CL_BDEFER, CL_REJECT
  } att_class_e;

  typedef enum logic [1:0] {DEC_OK, DEC_FAIL, DEC_RETRY} decision_e;
  typedef enum logic [1:0] {W_NONE, W_ACK, W_INV, W_DEFER} wait_e;

  localparam logic [3:0] RPL_ACK        = 4'h0;
  localparam logic [3:0] RPL_NACK       = 4'h1;
  localparam logic [3:0] RPL_DEFER      = 4'h2;
  localparam logic [3:0] RPL_I2C_NACK   = 4'h4;
  localparam logic [3:0] RPL_I2C_RDEFER = 4'h8;
  localparam logic [3:0] RPL_I2C_BDEFER = 4'hC;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/aux_att_classify.sv
`timescale 1ns/1ps
module aux_att_classify
  import aux_retry_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             hpd_i,
  input  logic [1:0]       tmo_i,
  input  logic [3:0]       inv_i,
  input  logic [3:0]       reply_i,
  input  logic [LEN_W:0]   rep_bytes_i,
  input  logic             is_read_i,
  input  logic [LEN_W-1:0] req_len_i,
  output att_class_e       class_o
);

  logic [LEN_W:0] need_bytes;
  assign need_bytes = {1'b0, req_len_i} + 1'b1;  // payload plus code byte

  always_comb begin
    if (hpd_i)                                  class_o = CL_HPD;
    else if (|tmo_i)                            class_o = CL_TMO;
    else if ((|inv_i) || (rep_bytes_i == '0))   class_o = CL_INV;
    else begin
      case (reply_i)
        RPL_ACK:        class_o = (is_read_i && (rep_bytes_i < need_bytes))
                                  ? CL_ACK_SHORT : CL_ACK_OK;
        RPL_DEFER:      class_o = CL_NDEFER;
        RPL_I2C_NACK:   class_o = CL_I2C_NACK;
        RPL_I2C_RDEFER: class_o = CL_RDEFER;
        RPL_I2C_BDEFER: class_o = CL_BDEFER;
        default:        class_o = CL_REJECT;  // native NACK and unknown codes
      endcase
    end
  end

endmodule

// File: rtl/aux_retry_budget.sv
`timescale 1ns/1ps
module aux_retry_budget
  import aux_retry_pkg::*;
#(
  parameter int MAX_ATT = 7,
  parameter int ACK_LIM = 7,
  parameter int DEF_LIM = 7,
  parameter int I2C_LIM = 7,
  parameter int INV_LIM = 2,
  parameter int TMO_LIM = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       launch_i,
  input  logic       eval_i,
  input  att_class_e class_i,
  input  logic       defer_nz_i,
  output decision_e  dec_o,
  output wait_e      wait_o
);

  localparam int NCAT = 5;
  localparam int C_ACK = 0, C_DEF = 1, C_I2C = 2, C_INV = 3, C_TMO = 4;
  localparam int LMAX = imax(imax(imax(ACK_LIM, DEF_LIM), imax(I2C_LIM, INV_LIM)), TMO_LIM);
  localparam int CW   = $clog2(LMAX + 1);
  localparam int CWP  = CW + 1;
  localparam int AW   = $clog2(MAX_ATT + 1);
  localparam int LIM [NCAT] = '{ACK_LIM, DEF_LIM, I2C_LIM, INV_LIM, TMO_LIM};

  logic [NCAT-1:0] inc, clr, at_lim;
  logic [AW-1:0]   att_q;
  logic            att_cap;

  always_comb begin
    inc = '0;
    clr = '0;
    case (class_i)
      CL_TMO: inc[C_TMO] = 1'b1;
      CL_INV: inc[C_INV] = 1'b1;
      CL_HPD: ;
      default: begin
        clr[C_TMO] = 1'b1;
        clr[C_INV] = 1'b1;
      end
    endcase
    case (class_i)
      CL_ACK_SHORT:                     inc[C_ACK] = 1'b1;
      CL_NDEFER, CL_I2C_NACK, CL_RDEFER: inc[C_DEF] = 1'b1;
      CL_BDEFER: begin
        clr[C_DEF] = 1'b1;
        inc[C_I2C] = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NCAT; g++) begin : g_cat
    logic [CW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (clear_i)                              q <= '0;
      else if (eval_i && clr[g])                     q <= '0;
      else if (eval_i && inc[g] && q != CW'(LIM[g])) q <= q + 1'b1;
    end
    // limit reached once this result is counted
    assign at_lim[g] = ({1'b0, q} + 1'b1) >= CWP'(LIM[g]);

    // R5 R6 R8 R10 R11: a budget never runs past its limit
    assert_cnt_budget_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q <= CW'(LIM[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               att_q <= '0;
    else if (clear_i)                          att_q <= '0;
    else if (launch_i && att_q != AW'(MAX_ATT)) att_q <= att_q + 1'b1;
  end
  assign att_cap = att_q >= AW'(MAX_ATT);

  always_comb begin
    dec_o  = DEC_FAIL;
    wait_o = W_NONE;
    case (class_i)
      CL_ACK_OK: dec_o = DEC_OK;
      CL_ACK_SHORT: if (!at_lim[C_ACK]) begin
        dec_o  = DEC_RETRY;
        wait_o = W_ACK;
      end
      CL_NDEFER, CL_RDEFER: if (!at_lim[C_DEF]) begin
        dec_o  = DEC_RETRY;
        wait_o = defer_nz_i ? W_DEFER : W_NONE;
      end
      CL_I2C_NACK: if (!at_lim[C_DEF]) dec_o = DEC_RETRY;
      CL_BDEFER:   if (!at_lim[C_I2C]) dec_o = DEC_RETRY;
      CL_INV: if (!at_lim[C_INV]) begin
        dec_o  = DEC_RETRY;
        wait_o = W_INV;
      end
      CL_TMO: if (!at_lim[C_TMO]) dec_o = DEC_RETRY;
      default: ;
    endcase
    if (dec_o == DEC_RETRY && att_cap) begin
      dec_o  = DEC_FAIL;
      wait_o = W_NONE;
    end
  end

  assert_att_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= AW'(MAX_ATT));
  assert_no_launch_past_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_q == AW'(MAX_ATT) && !clear_i) |=> att_q == AW'(MAX_ATT));

endmodule

// File: rtl/aux_wait_timer.sv
`timescale 1ns/1ps
module aux_wait_timer #(
  parameter int TW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          done_o
);

  logic [TW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q <= '0;
    else if (load_i)             q <= load_val_i;
    else if (tick_i && q != '0)  q <= q - 1'b1;
  end

  assign done_o = (q == '0);

  assert_tick_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i && q != '0) |=> q == $past(q) - 1'b1);
  assert_hold_no_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(q));

endmodule

// File: rtl/aux_retry_ctrl.sv
`timescale 1ns/1ps
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int LEN_W       = 5,
  parameter int DLY_W       = 8,
  parameter int US_PER_MS   = 1000,
  parameter int ACK_WAIT_US = 300,
  parameter int INV_WAIT_US = 400,
  parameter int MAX_ATT     = 7,
  parameter int ACK_LIM     = 7,
  parameter int DEF_LIM     = 7,
  parameter int I2C_LIM     = 7,
  parameter int INV_LIM     = 2,
  parameter int TMO_LIM     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_read_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [DLY_W-1:0] defer_ms_i,
  input  logic             tick_us_i,
  input  logic             att_done_i,
  input  logic             st_hpd_i,
  input  logic [1:0]       st_tmo_i,
  input  logic [3:0]       st_inv_i,
  input  logic [3:0]       reply_i,
  input  logic [LEN_W:0]   rep_bytes_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             done_ok_o,
  output logic             done_fail_o
);

  localparam int DEF_MAX  = ((1 << DLY_W) - 1) * US_PER_MS;
  localparam int WAIT_MAX = imax(DEF_MAX, imax(ACK_WAIT_US, INV_WAIT_US));
  localparam int TW       = $clog2(WAIT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_ATTEMPT, S_PAUSE} state_e;

  state_e           state_q;
  logic             rd_q;
  logic [LEN_W-1:0] len_q;
  logic             ok_q, fail_q;
  logic             accept, eval, tmr_load, tmr_done;
  att_class_e       att_class;
  decision_e        dec;
  wait_e            wt;
  logic [TW-1:0]    wait_val;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign eval     = (state_q == S_ATTEMPT) && att_done_i;
  assign tmr_load = eval && (dec == DEC_RETRY) && (wt != W_NONE);

  aux_att_classify #(.LEN_W(LEN_W)) u_cls (
    .hpd_i       (st_hpd_i),
    .tmo_i       (st_tmo_i),
    .inv_i       (st_inv_i),
    .reply_i     (reply_i),
    .rep_bytes_i (rep_bytes_i),
    .is_read_i   (rd_q),
    .req_len_i   (len_q),
    .class_o     (att_class)
  );

  aux_retry_budget #(
    .MAX_ATT (MAX_ATT), .ACK_LIM (ACK_LIM), .DEF_LIM (DEF_LIM),
    .I2C_LIM (I2C_LIM), .INV_LIM (INV_LIM), .TMO_LIM (TMO_LIM)
  ) u_bud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .launch_i   (launch_o),
    .eval_i     (eval),
    .class_i    (att_class),
    .defer_nz_i (|defer_ms_i),
    .dec_o      (dec),
    .wait_o     (wt)
  );

  always_comb begin
    case (wt)
      W_ACK:   wait_val = TW'(ACK_WAIT_US);
      W_INV:   wait_val = TW'(INV_WAIT_US);
      W_DEFER: wait_val = TW'(defer_ms_i) * TW'(US_PER_MS);
      default: wait_val = '0;
    endcase
  end

  aux_wait_timer #(.TW(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (wait_val),
    .tick_i     (tick_us_i),
    .done_o     (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rd_q    <= 1'b0;
      len_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_LAUNCH;
          rd_q    <= is_read_i;
          len_q   <= req_len_i;
        end
        S_LAUNCH: state_q <= S_ATTEMPT;
        S_ATTEMPT: if (att_done_i) begin
          if (dec != DEC_RETRY)  state_q <= S_IDLE;
          else if (wt == W_NONE) state_q <= S_LAUNCH;
          else                   state_q <= S_PAUSE;
        end
        S_PAUSE: if (tmr_done) state_q <= S_LAUNCH;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      ok_q   <= eval && (dec == DEC_OK);
      fail_q <= eval && (dec == DEC_FAIL);
    end
  end

  assign launch_o    = (state_q == S_LAUNCH);
  assign busy_o      = (state_q != S_IDLE);
  assign done_ok_o   = ok_q;
  assign done_fail_o = fail_q;

  assert_strobe_excl_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_ok_o && done_fail_o));
  assert_strobe_after_result_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ok_o || done_fail_o) |-> $past(att_done_i));
  assert_strobe_not_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ok_o || done_fail_o) |-> !busy_o);
  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !launch_o);
  assert_launch_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  assert_pause_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PAUSE && !tmr_done) |=> state_q == S_PAUSE);

endmodule

// File: tb/sim_aux_retry_ctrl.sv
`timescale 1ns/1ps
module sim_aux_retry_ctrl;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, is_read_i = 1'b0;
  logic [4:0] req_len_i = '0;
  logic [7:0] defer_ms_i = '0;
  logic       tick_us_i = 1'b1;
  logic       att_done_i = 1'b0, st_hpd_i = 1'b0;
  logic [1:0] st_tmo_i = '0;
  logic [3:0] st_inv_i = '0, reply_i = '0;
  logic [5:0] rep_bytes_i = '0;
  logic       launch_o, busy_o, done_ok_o, done_fail_o;

  always #2.5 clk = ~clk;

  aux_retry_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .is_read_i (is_read_i),
    .req_len_i (req_len_i), .defer_ms_i (defer_ms_i), .tick_us_i (tick_us_i),
    .att_done_i (att_done_i), .st_hpd_i (st_hpd_i), .st_tmo_i (st_tmo_i),
    .st_inv_i (st_inv_i), .reply_i (reply_i), .rep_bytes_i (rep_bytes_i),
    .launch_o (launch_o), .busy_o (busy_o), .done_ok_o (done_ok_o),
    .done_fail_o (done_fail_o)
  );

  int n_chk = 0, n_err = 0;
  int tick_div = 1;
  int poke_at = -1;
  int rsp_st [8];
  logic [3:0] rsp_rep [8];
  logic [5:0] rsp_by [8];
  int gaps [8];
  int n_att, done_gap, busy_bad;
  logic got_ok, got_fail;

  // status codes: 0 clean, 1/2 timeout flag, 3/7 invalid flag, 4 disconnect, 6 timeout+invalid
  typedef struct packed {
    logic rd; logic [4:0] len; logic [2:0] st; logic [3:0] rep;
    logic [5:0] by; logic [3:0] natt; logic ok;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd4, 3'd0, 4'h0, 6'd5, 4'd1, 1'b1},
    '{1'b1, 5'd4, 3'd0, 4'h0, 6'd3, 4'd7, 1'b0},
    '{1'b0, 5'd4, 3'd0, 4'h0, 6'd1, 4'd1, 1'b1},
    '{1'b1, 5'd4, 3'd0, 4'h0, 6'd7, 4'd1, 1'b1},
    '{1'b1, 5'd2, 3'd0, 4'h1, 6'd1, 4'd1, 1'b0},
    '{1'b1, 5'd2, 3'd0, 4'h5, 6'd1, 4'd1, 1'b0},
    '{1'b1, 5'd4, 3'd4, 4'h0, 6'd5, 4'd1, 1'b0},
    '{1'b1, 5'd4, 3'd1, 4'h0, 6'd5, 4'd3, 1'b0},
    '{1'b1, 5'd4, 3'd2, 4'h0, 6'd5, 4'd3, 1'b0},
    '{1'b1, 5'd4, 3'd3, 4'h0, 6'd5, 4'd2, 1'b0},
    '{1'b1, 5'd4, 3'd7, 4'h0, 6'd5, 4'd2, 1'b0},
    '{1'b1, 5'd4, 3'd0, 4'h0, 6'd0, 4'd2, 1'b0},
    '{1'b0, 5'd1, 3'd0, 4'h2, 6'd1, 4'd7, 1'b0},
    '{1'b0, 5'd1, 3'd0, 4'h4, 6'd1, 4'd7, 1'b0},
    '{1'b0, 5'd1, 3'd0, 4'h8, 6'd1, 4'd7, 1'b0},
    '{1'b0, 5'd1, 3'd0, 4'hC, 6'd1, 4'd7, 1'b0},
    '{1'b1, 5'd4, 3'd6, 4'h0, 6'd5, 4'd3, 1'b0},
    '{1'b1, 5'd0, 3'd0, 4'h0, 6'd1, 4'd1, 1'b1}
  };
  string vreq [NV] = '{"R4", "R5", "R4", "R4", "R9", "R9", "R2", "R11", "R11",
                       "R10", "R10", "R2", "R6", "R6", "R6", "R8", "R2", "R4"};

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_gap(input int st, input logic [3:0] rep, input int by, input int dms);
    if (st == 1 || st == 2 || st == 6) return 1;      // R11 no wait
    if (st == 3 || st == 7 || by == 0) return 402;    // R10 400 ticks
    if (rep == 4'h0) return 302;                      // R5 300 ticks
    if (rep == 4'h2 || rep == 4'h8) return (dms != 0) ? dms * 1000 + 2 : 1;  // R7
    return 1;
  endfunction

  task automatic set_all(input int st, input logic [3:0] rep, input logic [5:0] by);
    for (int i = 0; i < 8; i++) begin
      rsp_st[i] = st; rsp_rep[i] = rep; rsp_by[i] = by;
    end
  endtask

  task automatic drive_rsp(input int idx);
    st_hpd_i    = (rsp_st[idx] == 4);
    st_tmo_i    = {rsp_st[idx] == 2, rsp_st[idx] == 1 || rsp_st[idx] == 6};
    st_inv_i    = {rsp_st[idx] == 7, rsp_st[idx] == 3, 1'b0, rsp_st[idx] == 6};
    reply_i     = rsp_rep[idx];
    rep_bytes_i = rsp_by[idx];
  endtask

  task automatic run_txn(input logic rd, input logic [4:0] len);
    int gap, guard;
    n_att = 0; got_ok = 0; got_fail = 0; gap = 0; guard = 0; busy_bad = 0; done_gap = -1;
    @(negedge clk); start_i = 1'b1; is_read_i = rd; req_len_i = len;
    @(negedge clk); start_i = 1'b0; is_read_i = ~rd; req_len_i = 5'd31;
    while (!got_ok && !got_fail && guard < 40000) begin
      guard++;
      if (done_ok_o || done_fail_o) begin
        got_ok = done_ok_o; got_fail = done_fail_o; done_gap = gap;
        if (busy_o) busy_bad++;
      end else if (launch_o) begin
        if (n_att < 8) gaps[n_att] = gap;
        n_att++;
        @(negedge clk); @(negedge clk);
        drive_rsp((n_att > 8) ? 7 : n_att - 1);
        att_done_i = 1'b1;
        @(negedge clk);
        att_done_i = 1'b0; st_hpd_i = 0; st_tmo_i = '0; st_inv_i = '0; reply_i = '0; rep_bytes_i = '0;
        gap = 1;
      end else begin
        if (!busy_o) busy_bad++;
        start_i = (poke_at >= 0 && gap == poke_at);
        @(negedge clk);
        start_i = 1'b0;
        gap++;
      end
    end
    if (guard >= 40000) chk_eq("R1", "request never ended", 0, 1);
    @(negedge clk);
    // R14 strobe is one cycle, nothing follows it
    chk_eq("R14", "strobe after end", done_ok_o | done_fail_o | launch_o | busy_o, 0);
    chk_eq("R14", "strobe delay", done_gap, 1);
    chk_eq("R13", "busy violations", busy_bad, 0);
  endtask

  initial begin
    forever begin
      for (int k = 0; k < tick_div; k++) begin
        @(negedge clk);
        tick_us_i = (k == tick_div - 1);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk_eq("R13", "launch in reset", launch_o, 0);
    chk_eq("R13", "busy in reset", busy_o, 0);
    chk_eq("R13", "done in reset", done_ok_o | done_fail_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      set_all(int'(VECS[v].st), VECS[v].rep, VECS[v].by);
      run_txn(VECS[v].rd, VECS[v].len);
      chk_eq(vreq[v], $sformatf("vec %0d attempts", v), n_att, int'(VECS[v].natt));
      chk_eq(vreq[v], $sformatf("vec %0d success", v), got_ok, int'(VECS[v].ok));
      chk_eq(vreq[v], $sformatf("vec %0d fail", v), got_fail, int'(!VECS[v].ok));
      for (int a = 1; a < n_att && a < 8; a++)
        chk_eq("R12", $sformatf("vec %0d gap %0d", v, a), gaps[a],
               exp_gap(int'(VECS[v].st), VECS[v].rep, int'(VECS[v].by), 0));
    end

    // R3: a clean result clears the timeout budget
    set_all(1, 4'h0, 6'd1);
    rsp_st[2] = 0; rsp_rep[2] = 4'h2;
    rsp_st[5] = 0;
    run_txn(1'b0, 5'd2);
    chk_eq("R3", "attempts after clear", n_att, 6);
    chk_eq("R3", "success after clear", got_ok, 1);

    // R11: an invalid reply does not clear the timeout budget
    set_all(1, 4'h0, 6'd1);
    rsp_st[2] = 3;
    run_txn(1'b0, 5'd2);
    chk_eq("R11", "attempts tmo tmo inv tmo", n_att, 4);
    chk_eq("R11", "fail tmo tmo inv tmo", got_fail, 1);

    // R13: start while busy is ignored
    set_all(0, 4'h0, 6'd1);
    rsp_st[0] = 3;
    poke_at = 50;
    run_txn(1'b0, 5'd2);
    poke_at = -1;
    chk_eq("R13", "attempts with stray start", n_att, 2);
    chk_eq("R10", "invalid wait", gaps[1], 402);
    chk_eq("R13", "success with stray start", got_ok, 1);

    // R7: defer delay in milliseconds
    defer_ms_i = 8'd1;
    set_all(0, 4'h0, 6'd1); rsp_rep[0] = 4'h2;
    run_txn(1'b0, 5'd1);
    chk_eq("R7", "native defer wait", gaps[1], 1002);
    set_all(0, 4'h0, 6'd1); rsp_rep[0] = 4'h8;
    run_txn(1'b0, 5'd1);
    chk_eq("R7", "relay defer wait", gaps[1], 1002);
    set_all(0, 4'h0, 6'd1); rsp_rep[0] = 4'h4;
    run_txn(1'b0, 5'd1);
    chk_eq("R7", "i2c nack no wait", gaps[1], 1);
    chk_eq("R7", "i2c nack then ok", got_ok, 1);
    defer_ms_i = 8'd0;

    // R1: attempt ceiling while every budget is below its limit
    set_all(0, 4'h2, 6'd1);
    rsp_rep[4] = 4'hC; rsp_rep[5] = 4'hC; rsp_rep[6] = 4'hC; rsp_rep[7] = 4'hC;
    run_txn(1'b0, 5'd1);
    chk_eq("R1", "attempts at ceiling", n_att, 7);
    chk_eq("R1", "fail at ceiling", got_fail, 1);
    chk_eq("R8", "bus defer no wait", gaps[5], 1);

    // R12: half-rate tick doubles the wait
    tick_div = 2;
    set_all(0, 4'h0, 6'd1); rsp_st[0] = 3;
    run_txn(1'b0, 5'd1);
    n_chk++;
    if (gaps[1] < 800 || gaps[1] > 804) begin
      n_err++;
      $display("FAIL R12 slow tick wait: actual %0d expected %0d", gaps[1], 802);
    end
    tick_div = 1;
    repeat (4) @(negedge clk);

    // R13: a result with no attempt outstanding is ignored
    reply_i = 4'h0; rep_bytes_i = 6'd1; att_done_i = 1'b1;
    @(negedge clk); att_done_i = 1'b0;
    @(negedge clk);
    chk_eq("R13", "stray result strobes", done_ok_o | done_fail_o, 0);
    chk_eq("R13", "stray result launch", launch_o | busy_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule